// File: doc/BRIEF.md
# Signed Decade Result Counter

This block keeps the running result of a successive-integration converter while its de-integrate passes run. The count is held as six ten's-complement BCD decades. Each enabled cycle adds or subtracts one unit at a selectable decade. The sequencer lowers that decade by one on each later pass, and it sets the direction from the residue polarity. A later pass can therefore take back part of what an earlier pass added. The count is converted to sign plus BCD magnitude, which gives a display range of four full digits and a leading half digit (±19,999).

A one-cycle latch strobe copies the converted value into an output register and records the overrange flag (magnitude above 19,999) and the underrange flag (magnitude below 1,000). The register holds between strobes. When overrange is set, the four lower digits of the display output are blanked. A view select input shows the live count in place of the latched one, so the value can be watched while counting goes on.

Top module: `sdc_result_counter`

## Requirements
- R1: After reset the latched value reads +0 (disp_neg=0, disp_half=0, disp_dig=0) and ovr, undr and blank are low.
- R2: A clr cycle sets the live count to zero. If cnt_en is high in the same cycle, clr takes priority.
- R3: Each cycle with cnt_en high adds 10^wsel to the live count (cnt_down=0) or subtracts 10^wsel (cnt_down=1), for wsel in 0..3. Carries and borrows ripple into higher decades.
- R4: A negative count is presented as disp_neg=1 together with its BCD magnitude. A zero count is always presented with disp_neg=0.
- R5: On a latch cycle the output register takes the count as it stood before that edge, including when cnt_en is high in the same cycle. Without latch it holds its value.
- R6: On latch, ovr is set to 1 if the magnitude exceeds 19,999 and to 0 otherwise. It holds until the next latch.
- R7: On latch, undr is set to 1 if the magnitude is below 1,000 and to 0 otherwise. It holds until the next latch.
- R8: While the shown value is overrange, blank is 1, each of the four disp_dig nibbles reads 4'hF, and disp_half reads 1.
- R9: With show_live=1 the display outputs (disp_neg, disp_half, disp_dig, blank) follow the live count. ovr and undr keep their latched values.
- R10: disp_dig holds BCD units in [3:0], tens in [7:4], hundreds in [11:8] and thousands in [15:12]. disp_half is 1 for magnitudes from 10,000 to 19,999.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Zero the live count |
| cnt_en | input | 1 | Count one unit this cycle |
| cnt_down | input | 1 | 1 = subtract, 0 = add |
| wsel | input | 2 | Decade that receives the unit (0 = units .. 3 = thousands) |
| latch | input | 1 | Transfer the count to the output register |
| show_live | input | 1 | Show the live count instead of the latched value |
| disp_neg | output | 1 | Sign of the shown value |
| disp_half | output | 1 | Leading half digit |
| disp_dig | output | 16 | Four BCD digits of the shown value |
| ovr | output | 1 | Latched overrange flag |
| undr | output | 1 | Latched underrange flag |
| blank | output | 1 | Lower digits blanked |

## Verification
The latch strobe and a count step can fall in the same clock edge. The register must then capture the count as it was before the step, while the live count moves on. The bench raises latch and cnt_en in the same cycle. It then checks that the latched display shows the old value and that the live view shows the stepped value. A second collision, clear against count, is provoked the same way, and the live view must read zero.

// File: rtl/sdc_result_counter.sv
module sdc_result_counter #(
  parameter int NDIG = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        cnt_en,
  input  logic        cnt_down,
  input  logic [1:0]  wsel,
  input  logic        latch,
  input  logic        show_live,
  output logic        disp_neg,
  output logic        disp_half,
  output logic [15:0] disp_dig,
  output logic        ovr,
  output logic        undr,
  output logic        blank
);
  localparam int CW = 4 * NDIG;

  logic [NDIG-1:0][3:0] cnt, cnt_nxt, mag;
  logic live_neg, live_ovr, live_undr;

  always_comb begin
    logic cy;
    cy = 1'b0;
    cnt_nxt = cnt;
    for (int i = 0; i < NDIG; i++) begin
      if (i == int'(wsel)) cy = cnt_en;
      if (cy) begin
        if (cnt_down) begin
          cnt_nxt[i] = (cnt[i] == 4'd0) ? 4'd9 : cnt[i] - 4'd1;
          cy = (cnt[i] == 4'd0);
        end else begin
          cnt_nxt[i] = (cnt[i] == 4'd9) ? 4'd0 : cnt[i] + 4'd1;
          cy = (cnt[i] == 4'd9);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else           cnt <= cnt_nxt;

  assign live_neg = cnt[NDIG-1] >= 4'd5;

  always_comb begin
    logic k;
    logic [3:0] nine;
    k = 1'b1;
    for (int i = 0; i < NDIG; i++) begin
      nine = 4'd9 - cnt[i];
      if (!live_neg)   mag[i] = cnt[i];
      else if (k)      mag[i] = (nine == 4'd9) ? 4'd0 : nine + 4'd1;
      else             mag[i] = nine;
      k = k && (nine == 4'd9);
    end
  end

  always_comb begin
    live_ovr = mag[4] >= 4'd2;
    for (int i = 5; i < NDIG; i++)
      if (mag[i] != 4'd0) live_ovr = 1'b1;
  end

  assign live_undr = (mag[CW/4-1:3] == '0);

  logic [19:0] q_mag;
  logic        q_neg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q_mag <= '0;
      q_neg <= 1'b0;
      ovr   <= 1'b0;
      undr  <= 1'b0;
    end else if (latch) begin
      q_mag <= mag[4:0];
      q_neg <= live_neg;
      ovr   <= live_ovr;
      undr  <= live_undr;
    end

  logic [19:0] s_mag;
  assign s_mag     = show_live ? 20'(mag[4:0]) : q_mag;
  assign blank     = show_live ? live_ovr : ovr;
  assign disp_neg  = show_live ? live_neg : q_neg;
  assign disp_half = blank || (s_mag[19:16] != 4'd0);
  assign disp_dig  = blank ? 16'hFFFF : s_mag[15:0];
endmodule

// File: rtl/sdc_result_counter_chk.sv
module sdc_result_counter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        latch,
  input logic        show_live,
  input logic        disp_neg,
  input logic        disp_half,
  input logic [15:0] disp_dig,
  input logic        ovr,
  input logic        undr,
  input logic        blank
);
  logic started;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(clr) && show_live |-> disp_dig == 16'h0 && !disp_neg && !disp_half);

  // R4
  zero_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_dig == 16'h0 && !disp_half) |-> !disp_neg);

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started && !$past(latch) |-> $stable(ovr) && $stable(undr));

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovr && undr));

  // R8
  blank_dig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> disp_dig == 16'hFFFF && disp_half);

  // R7
  undr_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undr && !show_live |-> !disp_half && disp_dig[15:12] == 4'd0);
endmodule

bind sdc_result_counter sdc_result_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .latch(latch), .show_live(show_live),
  .disp_neg(disp_neg), .disp_half(disp_half), .disp_dig(disp_dig),
  .ovr(ovr), .undr(undr), .blank(blank)
);

// File: tb/sdc_result_counter_tb.sv
`timescale 1ns/1ps
module sdc_result_counter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic clr = 0, cnt_en = 0, cnt_down = 0, latch = 0, show_live = 0;
  logic [1:0] wsel = 0;
  logic disp_neg, disp_half, ovr, undr, blank;
  logic [15:0] disp_dig;
  int n_chk = 0, n_fail = 0;
  int v = 0;

  always #2 clk = ~clk;

  sdc_result_counter u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_en(cnt_en), .cnt_down(cnt_down),
    .wsel(wsel), .latch(latch), .show_live(show_live), .disp_neg(disp_neg),
    .disp_half(disp_half), .disp_dig(disp_dig), .ovr(ovr), .undr(undr), .blank(blank)
  );

  function automatic logic [15:0] bcd4(int m);
    return {4'(m / 1000 % 10), 4'(m / 100 % 10), 4'(m / 10 % 10), 4'(m % 10)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_disp(string tag, int val);
    int m = (val < 0) ? -val : val;
    logic o = m > 19999;
    chk({tag, " display"}, {28'd0, val < 0, o || m >= 10000, o, 1'b0},
        {28'd0, disp_neg, disp_half, blank, 1'b0});
    chk({tag, " digits"}, {16'd0, disp_dig}, {16'd0, o ? 16'hFFFF : bcd4(m)});
  endtask

  task automatic chk_flags(string tag, int val);
    int m = (val < 0) ? -val : val;
    chk({tag, " flags"}, {30'd0, ovr, undr}, {30'd0, m > 19999, m < 1000});
  endtask

  task automatic run(int n, bit dn, int w);
    @(negedge clk);
    cnt_en = 1; cnt_down = dn; wsel = 2'(w);
    repeat (n) @(negedge clk);
    cnt_en = 0;
    for (int i = 0; i < n; i++) v += (dn ? -1 : 1) * (10 ** w);
  endtask

  task automatic do_latch();
    @(negedge clk); latch = 1;
    @(negedge clk); latch = 0;
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    v = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset display", {disp_neg, disp_half, blank, disp_dig}, 19'd0);
    chk("R1 reset flags", {ovr, undr}, 2'b00);
  endtask

  task automatic t_passes();
    do_clr();
    run(2, 0, 3); run(3, 1, 2); run(5, 0, 1); run(7, 1, 0);
    do_latch();
    chk_disp("R3 R10 passes 1743", v);
    chk("R3 value", v, 1743);
    chk_flags("R6 R7 1743", v);
  endtask

  task automatic t_hold();
    run(4, 0, 3);
    @(negedge clk);
    chk_disp("R5 hold", 1743);
    chk_flags("R5 hold", 1743);
    show_live = 1; @(negedge clk);
    chk_disp("R9 live view", v);
    chk_flags("R9 flags stay latched", 1743);
    show_live = 0;
  endtask

  task automatic t_negative();
    do_clr();
    run(5, 1, 2);
    do_latch();
    chk_disp("R4 negative -500", v);
    chk_flags("R7 under -500", v);
  endtask

  task automatic t_zero();
    do_clr();
    run(3, 0, 1); run(3, 1, 1);
    do_latch();
    chk_disp("R4 zero positive", 0);
    chk("R4 zero sign", disp_neg, 1'b0);
  endtask

  task automatic t_bounds();
    do_clr();
    run(19, 0, 3); run(9, 0, 2); run(9, 0, 1); run(9, 0, 0);
    do_latch();
    chk_disp("R6 R10 19999", v);
    chk_flags("R6 19999 not over", v);
    run(1, 0, 0);
    do_latch();
    chk_disp("R8 20000 blank", v);
    chk_flags("R6 20000 over", v);
    do_clr();
    run(1, 0, 3);
    do_latch();
    chk_flags("R7 1000 not under", v);
    run(1, 1, 0);
    do_latch();
    chk_disp("R3 borrow 999", v);
    chk_flags("R7 999 under", v);
  endtask

  task automatic t_negover();
    do_clr();
    run(20, 1, 3);
    do_latch();
    chk_disp("R8 -20000 blank", v);
    chk_flags("R6 -20000 over", v);
    chk("R8 blank sign", disp_neg, 1'b1);
  endtask

  task automatic t_collide();
    do_clr();
    run(3, 0, 2);
    @(negedge clk);
    latch = 1; cnt_en = 1; cnt_down = 0; wsel = 2'd0;
    @(negedge clk);
    latch = 0; cnt_en = 0;
    chk_disp("R5 latch with count", 300);
    v += 1;
    show_live = 1; @(negedge clk);
    chk_disp("R5 live after collide", v);
    clr = 1; cnt_en = 1;
    @(negedge clk);
    clr = 0; cnt_en = 0; v = 0;
    chk_disp("R2 clr beats count", v);
    show_live = 0;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_passes();
    t_hold();
    t_negative();
    t_zero();
    t_bounds();
    t_negover();
    t_collide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule